// File: doc/BRIEF.md
# Selectable-Rate Pin Glitch Filter

This block cleans up a single external pin before it reaches an interrupt edge detector and a timer event input. The raw level is captured into the clock domain and then sampled at a rate chosen by software: every cycle, every 32 cycles or every 128 cycles. The filtered level moves to a new value only when two consecutive samples agree on it. Each sampling rate therefore comes with a guaranteed minimum pulse width that always passes, and a shorter width that never passes.

The filtered level is an output, so a timer can count its transitions. The block also produces one-cycle rise and fall pulses. It produces an interrupt pulse whose polarity (rising, falling or both) is selected by a two-bit edge mode. Level-sensitive detection is not offered. Software may switch the sampling rate at any time. A switch restarts the rate divider and leaves the filtered level untouched.

Top module: `pin_glitch_filter`

## Requirements
- R1: While `rst` is high, `level_out`, `rise_pulse`, `fall_pulse` and `irq_pulse` are 0, whatever `pin_raw` does.
- R2: `rate_sel` encoding: 0 samples every cycle, 1 samples every 32 cycles, and both 2 and 3 sample every 128 cycles.
- R3: `level_out` takes a new value only when two consecutive samples of the captured pin agree on it. At rate 0, a pin change made just after clock edge k shows on `level_out` after edge k+3 and not earlier.
- R4: At rate 0, a high or low pulse of 2 or more cycles always passes, and a 1-cycle pulse never passes.
- R5: At rate 1, a pulse of 64 or more cycles always passes, and a pulse shorter than 32 cycles never passes.
- R6: At rate 2, a pulse of 256 or more cycles always passes, and a pulse shorter than 128 cycles never passes.
- R7: Low pulses on a settled-high pin are accepted and rejected exactly as high pulses are on a settled-low pin.
- R8: `rise_pulse` (or `fall_pulse`) is high for exactly the one cycle after the edge at which `level_out` rises (or falls). The two are never high together.
- R9: `edge_mode` selects the interrupt: 0 gives none, 1 rising only, 2 falling only, 3 both. `irq_pulse` is high in the same cycle as the selected edge pulse and never without one.
- R10: A change of `rate_sel` restarts the sample divider and does not alter `level_out` at that edge. If `rate_sel` toggles between 2 and 3 more often than every 128 cycles, no sample is taken and `level_out` stays where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Unfiltered pin level |
| rate_sel | input | 2 | Sampling rate select (R2 encoding) |
| edge_mode | input | 2 | Interrupt edge polarity select (R9 encoding) |
| level_out | output | 1 | Filtered pin level, also the timer event source |
| rise_pulse | output | 1 | One-cycle pulse after a filtered rising edge |
| fall_pulse | output | 1 | One-cycle pulse after a filtered falling edge |
| irq_pulse | output | 1 | Interrupt request pulse for the selected polarity |

## Verification
At rate 0, a pin change driven between edges k-1 and k is captured at edge k and becomes the first sample at edge k+1. It reaches `level_out` at edge k+2, and the edge pulses and the interrupt are high during the following cycle. The latency test samples at the falling edge after each of these rising edges, so both the early and the on-time values are observed. At the slower rates the sample phase is free-running, so the exact arrival cycle varies. The width sweeps therefore count rise and fall pulses over a settle window of three divisor periods after each pulse, which is longer than the worst-case 2·N+3 cycle delay. They check only widths that are certain to pass or certain to be rejected.

// File: rtl/pin_filter_pkg.sv
package pin_filter_pkg;

    typedef enum logic [1:0] {
        RATE_FULL     = 2'd0,
        RATE_MID      = 2'd1,
        RATE_SLOW     = 2'd2,
        RATE_SLOW_ALT = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic logic irq_select(edge_e mode, edge_evt_t evt);
        logic want_rise;
        logic want_fall;
        want_rise = (mode == EDGE_RISE) || (mode == EDGE_BOTH);
        want_fall = (mode == EDGE_FALL) || (mode == EDGE_BOTH);
        return (want_rise & evt.rise) | (want_fall & evt.fall);
    endfunction

endpackage

// File: rtl/pin_filter_rate_gen.sv
module pin_filter_rate_gen
    import pin_filter_pkg::*;
#(
    parameter int DIV_MID  = 32,
    parameter int DIV_SLOW = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int CNT_W = $clog2(DIV_SLOW);
    localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(DIV_MID - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(DIV_SLOW - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    rate_e            sel_now;
    rate_e            sel_q;
    logic             sel_changed;

    assign sel_now = rate_e'(rate_sel);

    always_comb begin
        unique case (sel_now)
            RATE_FULL: limit = '0;
            RATE_MID:  limit = LIM_MID;
            default:   limit = LIM_SLOW;
        endcase
    end

    assign sel_changed = (sel_now != sel_q);
    assign tick        = !sel_changed && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= RATE_FULL;
        end else begin
            sel_q <= sel_now;
            if (sel_changed || tick) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pin_filter_vote.sv
module pin_filter_vote (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic tick,
    output logic level
);
    logic pin_q;
    logic smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
            smp   <= 1'b0;
            level <= 1'b0;
        end else begin
            pin_q <= pin_raw;
            if (tick) begin
                smp <= pin_q;
                if (pin_q == smp) level <= pin_q;
            end
        end
    end

endmodule

// File: rtl/pin_filter_edge.sv
module pin_filter_edge
    import pin_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  logic [1:0] edge_mode,
    output edge_evt_t  evt,
    output logic       irq
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign evt.rise = level & ~level_q;
    assign evt.fall = ~level & level_q;
    assign irq      = irq_select(edge_e'(edge_mode), evt);

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
    import pin_filter_pkg::*;
#(
    parameter int DIV_MID  = 32,
    parameter int DIV_SLOW = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  logic [1:0] rate_sel,
    input  logic [1:0] edge_mode,
    output logic       level_out,
    output logic       rise_pulse,
    output logic       fall_pulse,
    output logic       irq_pulse
);
    logic      tick;
    edge_evt_t evt;

    pin_filter_rate_gen #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) i_rate (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    pin_filter_vote i_vote (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_raw),
        .tick    (tick),
        .level   (level_out)
    );

    pin_filter_edge i_edge (
        .clk       (clk),
        .rst       (rst),
        .level     (level_out),
        .edge_mode (edge_mode),
        .evt       (evt),
        .irq       (irq_pulse)
    );

    assign rise_pulse = evt.rise;
    assign fall_pulse = evt.fall;

endmodule

// File: rtl/pin_glitch_filter_chk.sv
module pin_glitch_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       pin_raw,
    input logic [1:0] rate_sel,
    input logic [1:0] edge_mode,
    input logic       level_out,
    input logic       rise_pulse,
    input logic       fall_pulse,
    input logic       irq_pulse
);
    // R3
    level_vote_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_out) |-> ($past(pin_raw, 2) == level_out));

    // R8
    rise_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(level_out) |-> rise_pulse);

    // R8
    fall_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(level_out) |-> fall_pulse);

    // R8
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise_pulse && fall_pulse));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ((rise_pulse && edge_mode[0]) || (fall_pulse && edge_mode[1])));

    // R10
    sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |=> $stable(level_out));

    // R1
    always @(posedge clk) begin
        if (rst && $past(rst)) begin
            reset_quiet_chk: assert (!level_out && !rise_pulse && !fall_pulse && !irq_pulse);
        end
    end

endmodule

bind pin_glitch_filter pin_glitch_filter_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (pin_raw),
    .rate_sel   (rate_sel),
    .edge_mode  (edge_mode),
    .level_out  (level_out),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .irq_pulse  (irq_pulse)
);

// File: tb/test_pin_glitch_filter.sv
`timescale 1ns/1ps
module test_pin_glitch_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_raw = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [1:0] edge_mode = 2'd3;
    logic       level_out, rise_pulse, fall_pulse, irq_pulse;

    int n_chk = 0;
    int n_err = 0;
    int rise_n = 0;
    int fall_n = 0;
    int irq_n = 0;

    always #2.5 clk = ~clk;

    pin_glitch_filter i_pin_glitch_filter (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (pin_raw),
        .rate_sel   (rate_sel),
        .edge_mode  (edge_mode),
        .level_out  (level_out),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse),
        .irq_pulse  (irq_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            rise_n += int'(rise_pulse);
            fall_n += int'(fall_pulse);
            irq_n  += int'(irq_pulse);
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One pulse of polarity pol and given width on a settled pin.
    task automatic run_pulse(string req, int div, bit pol, int width, int pass);
        int r0, f0;
        pin_raw = !pol;
        repeat (3 * div + 8) @(negedge clk);
        r0 = rise_n;
        f0 = fall_n;
        pin_raw = pol;
        repeat (width) @(negedge clk);
        pin_raw = !pol;
        repeat (3 * div + 8) @(negedge clk);
        check(req, rise_n - r0, pass);
        check(req, fall_n - f0, pass);
        check(req, int'(level_out), int'(!pol));
    endtask

    // Widths each side of the guaranteed limits, both polarities.
    task automatic sweep(string req, int div, int code);
        int acc[2];
        int rej[2];
        rate_sel = 2'(code);
        acc[0] = 2 * div;
        acc[1] = 2 * div + div / 2 + 1;
        rej[0] = (div > 1) ? div - 1 : 1;
        rej[1] = (div > 1) ? div / 2 : 1;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 2; i++) begin
                run_pulse(req, div, p[0], acc[i], 1);
                run_pulse(req, div, p[0], rej[i], 0);
            end
        end
    endtask

    initial begin
        int i0;
        // R1: reset with the pin active
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        check("R1", int'(level_out), 0);
        check("R1", int'(rise_pulse | fall_pulse | irq_pulse), 0);
        pin_raw = 1'b0;
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R3/R8/R9: latency at rate 0, pin set between edge k-1 and edge k
        rate_sel = 2'd0;
        edge_mode = 2'd3;
        pin_raw = 1'b1;
        @(negedge clk);
        check("R3", int'(level_out), 0);
        @(negedge clk);
        check("R3", int'(level_out), 0);
        @(negedge clk);
        check("R3", int'(level_out), 1);
        check("R8", int'(rise_pulse), 1);
        check("R9", int'(irq_pulse), 1);
        @(negedge clk);
        check("R8", int'(rise_pulse), 0);
        check("R3", int'(level_out), 1);
        pin_raw = 1'b0;
        repeat (6) @(negedge clk);
        check("R3", int'(level_out), 0);

        // R4/R7 rate 0, R5/R7 rate 1, R6/R7 rate 2
        sweep("R4", 1, 0);
        sweep("R5", 32, 1);
        sweep("R6", 128, 2);
        // R2: rate 3 behaves as rate 2
        rate_sel = 2'd3;
        run_pulse("R2", 128, 1'b1, 256, 1);
        run_pulse("R2", 128, 1'b1, 127, 0);

        // R9: irq count per edge mode over one accepted high pulse
        rate_sel = 2'd0;
        for (int m = 0; m < 4; m++) begin
            edge_mode = 2'(m);
            pin_raw = 1'b0;
            repeat (8) @(negedge clk);
            i0 = irq_n;
            run_pulse("R9", 1, 1'b1, 5, 1);
            check("R9", irq_n - i0, (m & 1) + ((m >> 1) & 1));
        end
        edge_mode = 2'd3;

        // R10: select toggling every 20 cycles blocks all sampling
        rate_sel = 2'd2;
        pin_raw = 1'b0;
        repeat (400) @(negedge clk);
        pin_raw = 1'b1;
        for (int t = 0; t < 30; t++) begin
            rate_sel = (t % 2 == 0) ? 2'd3 : 2'd2;
            repeat (20) @(negedge clk);
        end
        check("R10", int'(level_out), 0);
        repeat (2 * 128 + 8) @(negedge clk);
        check("R10", int'(level_out), 1);
        // R10: a switch to rate 0 keeps the held level
        rate_sel = 2'd0;
        @(negedge clk);
        check("R10", int'(level_out), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule